// File: doc/BRIEF.md
# Lockable GPIO Port Controller

This block controls a port of general-purpose I/O pins, eight by default. For each pin, software holds five configuration bits: output data, direction, output type (push-pull or open-drain), pull enable and pull direction. The block turns these bits into the pad controls: output value, output enable, pull-up enable and pull-down enable. The pad's input level goes through a two-flop synchroniser and can be read as an input-data register. This read reflects the real line level, whatever the direction of the pin.

Each pin also has a lock bit. Software can set it but cannot clear it. Once it is set, that pin's five configuration bits are frozen until reset. A register write that touches locked and unlocked pins in the same word still updates the unlocked pins, so one write can be shared between locked and unlocked pins.

Registers are reached through a single-cycle write strobe and a combinational read port. Each register holds one bit per pin, with bit i belonging to pin i.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset, every configuration register and the lock register read 0. The pad output enable, output value, pull-up enable and pull-down enable are all 0.
- R2: The register addresses are: output data at 0, direction at 1, output type at 2, pull enable at 3, pull direction at 4, lock at 5 and input data at 6. An unlocked write stores wdata in the addressed register, and the stored value is read back at that address.
- R3: A pin with direction bit 1 and output-type bit 0 (push-pull) has its output enable asserted and drives its pad output from its output-data bit. A pin with direction bit 0 has its output enable deasserted.
- R4: A pin with output-type bit 1 (open-drain) asserts output enable only when its direction bit is 1 and its output-data bit is 0. Its pad output value is always 0.
- R5: When a pin's pull-enable bit is 1, a pull-direction bit of 0 asserts pull-up and a pull-direction bit of 1 asserts pull-down. When pull enable is 0, neither pull is asserted. Pull-up and pull-down are never asserted together.
- R6: The input-data register (address 6) shows pad_in as sampled two clock edges earlier. This holds for pins configured as outputs as well.
- R7: A write to the lock register ORs wdata into the lock bits. Writing 0 never clears a lock bit, and only reset clears one.
- R8: While a pin's lock bit is 1, writes leave that pin's output-data, direction, output-type, pull-enable and pull-direction bits unchanged.
- R9: In a write that covers both locked and unlocked pins, the unlocked pins take the new value in that same write.
- R10: A read of address 7 returns 0. A write to address 6 or 7 changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | PIN_W | Write data, one bit per pin |
| rdata | output | PIN_W | Read data for addr (combinational) |
| pad_in | input | PIN_W | Level present on each pad |
| pad_out | output | PIN_W | Value driven toward each pad |
| pad_oe | output | PIN_W | Per-pad output enable |
| pad_pu | output | PIN_W | Per-pad pull-up enable |
| pad_pd | output | PIN_W | Per-pad pull-down enable |

## Verification
The assertions assume that wr_en, addr and wdata change only away from the active clock edge, so every write is registered exactly once. They also assume that reset is applied before the first check. The bench drives all inputs on the falling edge and holds wr_en for exactly one rising edge. pad_in can be asynchronous in a real system, but the bench changes it only on falling edges, so the two-edge latency of the synchroniser can be counted exactly.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

    localparam int ADDR_W     = 3;
    localparam int NUM_FIELDS = 5;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DOUT  = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_OTYPE = 3'd2,
        SEL_PEN   = 3'd3,
        SEL_PDIR  = 3'd4,
        SEL_LOCK  = 3'd5,
        SEL_DIN   = 3'd6,
        SEL_NONE  = 3'd7
    } gpio_sel_e;

endpackage

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
    import gpio_lock_pkg::*;
#(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_sel_e        wr_sel,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] dout_q,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] otype_q,
    output logic [PIN_W-1:0] pen_q,
    output logic [PIN_W-1:0] pdir_q,
    output logic [PIN_W-1:0] lock_q
);

    logic [PIN_W-1:0] field_q [NUM_FIELDS];

    // lock register: write-one-to-set, cleared only by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (wr_en && wr_sel == SEL_LOCK) begin
            lock_q <= lock_q | wdata;
        end
    end

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_q) & ~lock_q) == '0);

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam gpio_sel_e FSEL = gpio_sel_e'(f);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q[f] <= '0;
            end else if (wr_en && wr_sel == FSEL) begin
                field_q[f] <= (field_q[f] & lock_q) | (wdata & ~lock_q);
            end
        end

        // R8
        locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((field_q[f] ^ $past(field_q[f])) & $past(lock_q)) == '0);
    end

    assign dout_q  = field_q[0];
    assign dir_q   = field_q[1];
    assign otype_q = field_q[2];
    assign pen_q   = field_q[3];
    assign pdir_q  = field_q[4];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PIN_W  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] async_in,
    output logic [PIN_W-1:0] sync_out
);

    logic [PIN_W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= async_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int PIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] dout,
    input  logic [PIN_W-1:0] dir,
    input  logic [PIN_W-1:0] otype,
    input  logic [PIN_W-1:0] pen,
    input  logic [PIN_W-1:0] pdir,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe,
    output logic [PIN_W-1:0] pad_pu,
    output logic [PIN_W-1:0] pad_pd
);

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        always_comb begin
            if (otype[i]) begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = dir[i] & ~dout[i];
            end else begin
                pad_out[i] = dout[i];
                pad_oe[i]  = dir[i];
            end
            pad_pu[i] = pen[i] & ~pdir[i];
            pad_pd[i] = pen[i] & pdir[i];
        end

        // R4
        od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            otype[i] |-> !pad_out[i]);

        // R5
        pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_pu[i] && pad_pd[i]));

        // R3
        oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> dir[i]);
    end

endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
    import gpio_lock_pkg::*;
#(
    parameter int PIN_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIN_W-1:0]  wdata,
    output logic [PIN_W-1:0]  rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_pu,
    output logic [PIN_W-1:0]  pad_pd
);

    gpio_sel_e        sel;
    logic [PIN_W-1:0] dout_q, dir_q, otype_q, pen_q, pdir_q, lock_q;
    logic [PIN_W-1:0] din_sync;

    assign sel = gpio_sel_e'(addr);

    gpio_cfg_bank #(.PIN_W(PIN_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wdata   (wdata),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .otype_q (otype_q),
        .pen_q   (pen_q),
        .pdir_q  (pdir_q),
        .lock_q  (lock_q)
    );

    gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    gpio_pad_ctrl #(.PIN_W(PIN_W)) u_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .dout    (dout_q),
        .dir     (dir_q),
        .otype   (otype_q),
        .pen     (pen_q),
        .pdir    (pdir_q),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu),
        .pad_pd  (pad_pd)
    );

    always_comb begin
        unique case (sel)
            SEL_DOUT:  rdata = dout_q;
            SEL_DIR:   rdata = dir_q;
            SEL_OTYPE: rdata = otype_q;
            SEL_PEN:   rdata = pen_q;
            SEL_PDIR:  rdata = pdir_q;
            SEL_LOCK:  rdata = lock_q;
            SEL_DIN:   rdata = din_sync;
            SEL_NONE:  rdata = '0;
        endcase
    end

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (sel == SEL_DIN || sel == SEL_NONE)) |=>
            $stable(pad_oe) && $stable(pad_out) && $stable(pad_pu) && $stable(pad_pd));

endmodule

// File: tb/gpio_lock_port_bench.sv
module gpio_lock_port_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] rdata, pad_out, pad_oe, pad_pu, pad_pd;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    gpio_lock_port u_gpio_lock_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    // vector: addr, wdata, expected oe, out, pu, pd after the write
    typedef struct packed {
        logic [2:0]   a;
        logic [W-1:0] d;
        logic [W-1:0] oe;
        logic [W-1:0] out;
        logic [W-1:0] pu;
        logic [W-1:0] pd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 8'hF0, 8'hF0, 8'h00, 8'h00, 8'h00},
        '{3'd0, 8'hA5, 8'hF0, 8'hA5, 8'h00, 8'h00},
        '{3'd2, 8'h30, 8'hD0, 8'h85, 8'h00, 8'h00},
        '{3'd3, 8'h0F, 8'hD0, 8'h85, 8'h0F, 8'h00},
        '{3'd4, 8'h05, 8'hD0, 8'h85, 8'h0A, 8'h05},
        '{3'd0, 8'h5A, 8'hE0, 8'h4A, 8'h0A, 8'h05},
        '{3'd7, 8'hFF, 8'hE0, 8'h4A, 8'h0A, 8'h05}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [W-1:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pads_check(input string req, input vec_t v);
        check({req, " oe"},  pad_oe,  v.oe);
        check({req, " out"}, pad_out, v.out);
        check({req, " pu"},  pad_pu,  v.pu);
        check({req, " pd"},  pad_pd,  v.pd);
    endtask

    initial begin
        #40000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < 6; r++) rd_check("R1 reg", 3'(r), 8'h00);
        pads_check("R1 pads", '{3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});

        // R2 R3 R4 R5 R10 vector walk
        for (int k = 0; k < NV; k++) begin
            wr(VECS[k].a, VECS[k].d);
            pads_check("R3/R4/R5/R10 vec", VECS[k]);
        end
        rd_check("R2 dout", 3'd0, 8'h5A);
        rd_check("R2 dir", 3'd1, 8'hF0);
        rd_check("R2 otype", 3'd2, 8'h30);
        rd_check("R2 pen", 3'd3, 8'h0F);
        rd_check("R2 pdir", 3'd4, 8'h05);
        rd_check("R10 unmapped read", 3'd7, 8'h00);

        // R6 input sync latency, including output pins
        @(negedge clk);
        pad_in = 8'h3C;
        addr = 3'd6;
        @(negedge clk);
        rd_check("R6 one edge", 3'd6, 8'h00);
        @(negedge clk);
        rd_check("R6 two edges", 3'd6, 8'h3C);
        wr(3'd6, 8'hFF);
        rd_check("R10 din write ignored", 3'd6, 8'h3C);
        rd_check("R10 dout untouched", 3'd0, 8'h5A);

        // R7 R8 R9 locking
        wr(3'd5, 8'h0F);
        rd_check("R7 lock set", 3'd5, 8'h0F);
        wr(3'd1, 8'h0F);
        rd_check("R8 R9 dir mixed", 3'd1, 8'h00);
        wr(3'd3, 8'hF0);
        rd_check("R8 R9 pen mixed", 3'd3, 8'hFF);
        wr(3'd0, 8'h00);
        rd_check("R8 R9 dout mixed", 3'd0, 8'h0A);
        wr(3'd4, 8'hFF);
        rd_check("R8 pdir locked", 3'd4, 8'hF5);
        wr(3'd2, 8'h00);
        rd_check("R8 otype locked", 3'd2, 8'h00);
        wr(3'd5, 8'h00);
        rd_check("R7 lock not cleared", 3'd5, 8'h0F);
        wr(3'd5, 8'h80);
        rd_check("R7 lock accumulates", 3'd5, 8'h8F);

        // R7 reset clears lock
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R7 R1 lock after reset", 3'd5, 8'h00);
        wr(3'd1, 8'hFF);
        rd_check("R7 writable after reset", 3'd1, 8'hFF);

        // R4 open-drain with all outputs
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'h0F);
        check("R4 od oe", pad_oe, 8'hF0);
        check("R4 od out", pad_out, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule